// File: doc/BRIEF.md
# Microwire serial master controller

A register-mapped serial master that runs one Microwire-style transaction at a time on one of four chip selects. Software loads a 16-bit transmit word, left-justified, then writes a command word. The command word gives the number of bits to send, the number of bits to receive, the target chip select and two command bits: one asserts the chip select and one starts the shift. The block drives the serial clock and first sends the transmit bits MSB-first. It then clocks in the receive bits MSB-first and makes them available, right-justified, in the read-data register.

Each chip select has its own 6-bit setup field. The field picks the clock divider, the edge on which output data changes, the edge on which input data is sampled and the chip-select pin polarity. A global setting chooses an idle-high serial clock. A separate enable bit must be set before any transfer can start. The chip select stays asserted after a transfer until software writes a command with the assert bit clear, so several words can form one frame.

Top module: `mw_master`

## Requirements
- R1: After reset cs_n is 4'b1111, sclk and sdo are 0, and the status word (index 1) and read data (index 0) read 0.
- R2: Index 0 is write-transmit/read-receive. Index 1 is command/status: bits [4:0] receive count, [9:5] transmit count, [11:10] chip-select number, 12 assert chip select, 13 start (reads 0), 14 busy, 15 receive pending. Indices 2 to 6 are five 16-bit setup registers and read back what was written.
- R3: A start command does nothing (busy stays 0) unless bit 0 of setup register 3 (index 4) is 1. The chip-select and count fields of that command are still stored.
- R4: Busy reads 1 from the cycle after the start write for exactly 2*2^d*(tx+rx) cycles, where d is the divider field of the selected chip select.
- R5: Transmit bits come from transmit register bits [15:16-N] and go out MSB first, one per serial-clock period.
- R6: Receive bits are shifted in MSB first and read back right-justified, with the unused upper bits 0. Status bit 15 is 1 during a receive and 0 once the data is in the read-data register.
- R7: With a receive count of 0, status bit 15 stays 0 and the read-data register keeps its value. With a transmit count of 0, only receive bits are clocked and sdo stays 0.
- R8: Command bit 12 asserts the selected chip select, which stays asserted after the transfer until a command write with bit 12 clear. Command writes made while busy are ignored.
- R9: The setup field of chip select c is bits [6*(c%2)+5 : 6*(c%2)] of setup register 1 (index 2) for c<2, and of setup register 2 (index 3) for c>=2. Field bits [4:2] give the divider d.
- R10: Field bit 0 = 0 puts each sdo bit out before the first clock edge of its bit period. Field bit 0 = 1 puts it out at that first edge.
- R11: Field bit 1 = 0 samples sdi at the first clock edge of a bit period. Field bit 1 = 1 samples it at the second edge.
- R12: Field bit 5 = 1 makes that chip-select pin active-high (idle low). With bit 5 = 0 the pin is active-low.
- R13: Bit 0 of setup register 4 (index 5) sets the idle level of sclk. In each bit period sclk first holds the idle level and then the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational on bus_addr) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select pins |

## Verification
Register writes and chip-select changes take effect at the clock edge that accepts the write. The bench reads them at the falling edge that follows, once its write task has returned. Busy is counted at each falling edge from that point and must last exactly 2*2^d*(tx+rx) cycles. A falling-edge monitor watches every sclk transition: it records sdo as it was just before each first and second edge of a bit period. It also changes sdi to the complement of the bit after the first edge, so the received word shows which edge the design sampled. Read data and pending flags are read after busy has fallen.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int DW  = 16;        // register width
  localparam int AW  = 3;         // register index width
  localparam int CW  = 5;         // bit count field width
  localparam int NCS = 4;         // chip selects
  localparam int CSW = $clog2(NCS);
  localparam int FW  = 6;         // per-select setup field width
  localparam int DVW = 3;         // divider exponent width
  localparam int HW  = 1 << DVW;  // half-period counter width
  localparam int BW  = CW + 1;    // bit index width (tx + rx)
  localparam int NSET = 5;        // setup registers

  // setup field layout
  localparam int F_LAUNCH = 0;
  localparam int F_SAMPLE = 1;
  localparam int F_DIV_LO = 2;
  localparam int F_POL    = 5;

  // command/status bit positions
  localparam int C_ASSERT = 12;
  localparam int C_START  = 13;

  function automatic logic [HW-1:0] half_len(input logic [DVW-1:0] d);
    return HW'(1) << d;
  endfunction

  function automatic logic tx_bit(input logic [DW-1:0] w, input logic [BW-1:0] k,
                                  input logic [CW-1:0] n);
    if (k < BW'(n) && int'(k) < DW) return w[DW-1-int'(k)];
    return 1'b0;
  endfunction

  function automatic logic [FW-1:0] field_of(input logic [DW-1:0] s1, input logic [DW-1:0] s2,
                                             input logic [CSW-1:0] cs);
    logic [DW-1:0] src;
    src = cs[1] ? s2 : s1;
    return cs[0] ? src[2*FW-1:FW] : src[FW-1:0];
  endfunction
endpackage

// File: rtl/mw_regs.sv
module mw_regs import mw_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           busy,
  input  logic           rx_pend,
  input  logic [DW-1:0]  rx_word,
  output logic [DW-1:0]  tx_word,
  output logic [CW-1:0]  cmd_tx,
  output logic [CW-1:0]  cmd_rx,
  output logic           cmd_launch,
  output logic           cmd_sample,
  output logic [DVW-1:0] cmd_div,
  output logic           start,
  output logic           enable,
  output logic           cs_on,
  output logic [CSW-1:0] cs_num,
  output logic [NCS-1:0] cs_pol,
  output logic           clk_idle
);
  logic [DW-1:0]  setup_q [NSET];
  logic [CW-1:0]  txc_q, rxc_q;
  logic [FW-1:0]  fld;
  logic           wr_ctl;

  assign wr_ctl  = wr && addr == AW'(1) && !busy;
  assign enable  = setup_q[2][0];
  assign clk_idle = setup_q[3][0];
  assign fld     = field_of(setup_q[0], setup_q[1], wdata[11:10]);
  assign cmd_tx  = wdata[9:5];
  assign cmd_rx  = wdata[4:0];
  assign cmd_launch = fld[F_LAUNCH];
  assign cmd_sample = fld[F_SAMPLE];
  assign cmd_div    = fld[F_DIV_LO +: DVW];
  assign start   = wr_ctl && wdata[C_START] && enable && (cmd_tx != '0 || cmd_rx != '0);

  for (genvar g = 0; g < NCS; g++) begin : g_pol
    logic [FW-1:0] f;
    assign f = field_of(setup_q[0], setup_q[1], CSW'(g));
    assign cs_pol[g] = f[F_POL];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
      txc_q <= '0;
      rxc_q <= '0;
      cs_on <= 1'b0;
      cs_num <= '0;
      for (int i = 0; i < NSET; i++) setup_q[i] <= '0;
    end else begin
      if (wr && addr == AW'(0)) tx_word <= wdata;
      if (wr_ctl) begin
        rxc_q  <= wdata[4:0];
        txc_q  <= wdata[9:5];
        cs_num <= wdata[11:10];
        cs_on  <= wdata[C_ASSERT];
      end
      for (int i = 0; i < NSET; i++)
        if (wr && addr == AW'(i + 2)) setup_q[i] <= wdata;
    end
  end

  always_comb begin
    case (addr)
      AW'(0): rdata = rx_word;
      AW'(1): rdata = {rx_pend, busy, 1'b0, cs_on, cs_num, txc_q, rxc_q};
      AW'(2): rdata = setup_q[0];
      AW'(3): rdata = setup_q[1];
      AW'(4): rdata = setup_q[2];
      AW'(5): rdata = setup_q[3];
      AW'(6): rdata = setup_q[4];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter import mw_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  tx_word,
  input  logic [CW-1:0]  tx_cnt,
  input  logic [CW-1:0]  rx_cnt,
  input  logic           launch,
  input  logic           sample,
  input  logic [DVW-1:0] div,
  input  logic           clk_idle,
  input  logic           sdi,
  output logic           busy,
  output logic           rx_pend,
  output logic           sclk,
  output logic           sdo,
  output logic [DW-1:0]  rx_word,
  output logic           done_evt,
  output logic           sample_evt
);
  logic           phase_q, launch_q, samp_q, rxe_q;
  logic [DVW-1:0] div_q;
  logic [DW-1:0]  txw_q, rxs_q, rx_next;
  logic [CW-1:0]  txn_q;
  logic [BW-1:0]  tot_q, bit_q;
  logic [HW-1:0]  cnt_q;
  logic           half_end, in_rx, last_bit;

  assign half_end   = busy && cnt_q == half_len(div_q) - HW'(1);
  assign in_rx      = bit_q >= BW'(txn_q);
  assign last_bit   = bit_q == tot_q - BW'(1);
  assign sample_evt = half_end && (phase_q == samp_q) && in_rx;
  assign done_evt   = half_end && phase_q && last_bit;
  assign rx_next    = sample_evt ? {rxs_q[DW-2:0], sdi} : rxs_q;
  assign sclk       = clk_idle ^ (busy & phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rx_pend <= 1'b0; sdo <= 1'b0; rx_word <= '0;
      phase_q <= 1'b0; launch_q <= 1'b0; samp_q <= 1'b0; rxe_q <= 1'b0;
      div_q <= '0; txw_q <= '0; rxs_q <= '0; txn_q <= '0;
      tot_q <= '0; bit_q <= '0; cnt_q <= '0;
    end else begin
      rxs_q <= rx_next;
      if (start && !busy) begin
        busy <= 1'b1; phase_q <= 1'b0; bit_q <= '0; cnt_q <= '0;
        launch_q <= launch; samp_q <= sample; div_q <= div;
        txw_q <= tx_word; txn_q <= tx_cnt;
        tot_q <= BW'(tx_cnt) + BW'(rx_cnt);
        rxe_q <= rx_cnt != '0; rx_pend <= rx_cnt != '0;
        rxs_q <= '0;
        if (!launch) sdo <= tx_bit(tx_word, '0, tx_cnt);
      end else if (half_end) begin
        cnt_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
          if (launch_q) sdo <= tx_bit(txw_q, bit_q, txn_q);
        end else if (last_bit) begin
          busy <= 1'b0; phase_q <= 1'b0; sdo <= 1'b0; rx_pend <= 1'b0;
          if (rxe_q) rx_word <= rx_next;
        end else begin
          bit_q <= bit_q + BW'(1);
          phase_q <= 1'b0;
          if (!launch_q) sdo <= tx_bit(txw_q, bit_q + BW'(1), txn_q);
        end
      end else if (busy) begin
        cnt_q <= cnt_q + HW'(1);
      end
    end
  end
endmodule

// File: rtl/mw_cs.sv
module mw_cs import mw_pkg::*; (
  input  logic           cs_on,
  input  logic [CSW-1:0] cs_num,
  input  logic [NCS-1:0] cs_pol,
  output logic [NCS-1:0] cs_n
);
  for (genvar g = 0; g < NCS; g++) begin : g_pin
    logic act;
    assign act = cs_on && cs_num == CSW'(g);
    assign cs_n[g] = act ? cs_pol[g] : ~cs_pol[g];
  end
endmodule

// File: rtl/mw_master.sv
module mw_master import mw_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi,
  output logic [3:0]    cs_n
);
  logic           busy, rx_pend, start_evt, enable, cs_on, clk_idle;
  logic           done_evt, sample_evt, cmd_launch, cmd_sample;
  logic [DW-1:0]  tx_word, rx_word;
  logic [CW-1:0]  cmd_tx, cmd_rx;
  logic [DVW-1:0] cmd_div;
  logic [CSW-1:0] cs_num;
  logic [NCS-1:0] cs_pol;

  mw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .busy(busy), .rx_pend(rx_pend), .rx_word(rx_word),
    .tx_word(tx_word), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_launch(cmd_launch),
    .cmd_sample(cmd_sample), .cmd_div(cmd_div), .start(start_evt), .enable(enable),
    .cs_on(cs_on), .cs_num(cs_num), .cs_pol(cs_pol), .clk_idle(clk_idle)
  );

  mw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .tx_word(tx_word),
    .tx_cnt(cmd_tx), .rx_cnt(cmd_rx), .launch(cmd_launch), .sample(cmd_sample),
    .div(cmd_div), .clk_idle(clk_idle), .sdi(sdi), .busy(busy), .rx_pend(rx_pend),
    .sclk(sclk), .sdo(sdo), .rx_word(rx_word), .done_evt(done_evt),
    .sample_evt(sample_evt)
  );

  mw_cs u_cs (.cs_on(cs_on), .cs_num(cs_num), .cs_pol(cs_pol), .cs_n(cs_n));
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rx_pend,
  input logic       start_evt,
  input logic       done_evt,
  input logic       sample_evt,
  input logic       cs_on,
  input logic [1:0] cs_num,
  input logic       sclk,
  input logic       clk_idle
);
  p_pend_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend |-> busy);
  p_samp_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> busy);
  p_rise_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt));
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy && !rx_pend);
  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs_num) && $stable(cs_on));
  p_idle_clk_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sclk == clk_idle);
endmodule

bind mw_master mw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rx_pend(rx_pend), .start_evt(start_evt),
  .done_evt(done_evt), .sample_evt(sample_evt), .cs_on(cs_on), .cs_num(cs_num),
  .sclk(sclk), .clk_idle(clk_idle)
);

// File: tb/mw_master_tb.sv
`timescale 1ns/1ps
module mw_master_tb;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, sdi = 1'b0;
  logic [2:0]  bus_addr = 3'd1;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        sclk, sdo;
  logic [3:0]  cs_n;
  int errors = 0, checks = 0;

  mw_master u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .cs_n(cs_n));

  always #4 clk = ~clk;

  // slave-side monitor state
  int m_tx, m_rx, m_edges;
  logic [15:0] m_slv;
  logic [63:0] m_pre, m_sec;
  logic m_arm = 1'b0, m_sclk_l = 1'b0, m_sdo_l = 1'b0;

  function automatic logic sdi_bit(input int k, input int txn, input int rxn, input logic [15:0] s);
    if (k < txn || k >= txn + rxn) return 1'b0;
    return s[rxn - 1 - (k - txn)];
  endfunction

  function automatic logic [31:0] pack(input logic [63:0] v, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r = (r << 1) | 32'(v[k]);
    return r;
  endfunction

  always @(negedge clk) begin
    if (m_arm && sclk !== m_sclk_l) begin
      if (m_edges % 2 == 0) begin
        m_pre[m_edges/2] = m_sdo_l;
        sdi = ~sdi_bit(m_edges/2, m_tx, m_rx, m_slv);
      end else begin
        m_sec[m_edges/2] = m_sdo_l;
        sdi = sdi_bit(m_edges/2 + 1, m_tx, m_rx, m_slv);
      end
      m_edges++;
    end
    m_sclk_l = sclk;
    m_sdo_l = sdo;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 3'd1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_addr = 3'd1;
  endtask

  // run one transfer; cyc = falling edges with busy seen
  task automatic xfer(input int cs, input int txn, input int rxn, input logic [15:0] txw,
                      input logic [15:0] slv, input bit poke, output int cyc, output bit pend_seen);
    m_tx = txn; m_rx = rxn; m_slv = slv; m_edges = 0; m_pre = '0; m_sec = '0;
    sdi = sdi_bit(0, txn, rxn, slv);
    bus_write(3'd0, txw);
    m_arm = 1'b1;
    bus_write(3'd1, 16'h3000 | (16'(cs) << 10) | (16'(txn) << 5) | 16'(rxn));
    #1 pend_seen = bus_rdata[15];
    if (poke) bus_write(3'd1, 16'h3C00 | 16'h0020);
    cyc = 0;
    #1;
    while (bus_rdata[14]) begin cyc++; @(negedge clk); #1; end
    m_arm = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 sdo", 32'(sdo), 0);
    bus_read(3'd1, d); chk("R1 status", 32'(d), 0);
    bus_read(3'd0, d); chk("R1 rxdata", 32'(d), 0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_write(3'd6, 16'hA5C3);
    bus_read(3'd6, d); chk("R2 setup5 readback", 32'(d), 32'hA5C3);
    bus_read(3'd7, d); chk("R2 unmapped index", 32'(d), 0);
  endtask

  task automatic t_enable;
    logic [15:0] d;
    bus_write(3'd1, 16'h3000 | (16'd8 << 5));
    #1 chk("R3 no busy while disabled", 32'(bus_rdata[14]), 0);
    bus_read(3'd1, d); chk("R3 fields stored", 32'(d), 32'h1100);
    chk("R3 cs still asserted", 32'(cs_n), 32'hE);
    bus_write(3'd4, 16'h0001);
    bus_read(3'd4, d); chk("R2 setup3 readback", 32'(d), 1);
  endtask

  task automatic t_tx;
    int cyc; bit pd; logic [15:0] d;
    xfer(0, 8, 0, 16'hB700, 16'h0, 1'b0, cyc, pd);
    chk("R4 busy cycles div0", 32'(cyc), 16);
    chk("R5 sdo word", pack(m_sec, 8), 32'hB7);
    chk("R10 launch before first edge", pack(m_pre, 8), 32'hB7);
    chk("R7 no pending without rx", 32'(pd), 0);
    bus_read(3'd0, d); chk("R7 rxdata unchanged", 32'(d), 0);
    bus_read(3'd1, d); chk("R8 status after tx", 32'(d), 32'h1100);
    chk("R8 cs0 held", 32'(cs_n), 32'hE);
  endtask

  task automatic t_rx;
    int cyc; bit pd; logic [15:0] d;
    bus_write(3'd2, 16'h0100);  // cs1 divider 1
    xfer(1, 3, 12, 16'hA000, 16'h0C3A, 1'b1, cyc, pd);
    chk("R6 pending during rx", 32'(pd), 1);
    chk("R5 sdo 3 bits", pack(m_sec, 3), 32'h5);
    chk("R9 cs1 divider edge count", 32'(m_edges), 30);
    bus_read(3'd0, d); chk("R6 rx right-justified", 32'(d), 32'h0C3A);
    bus_read(3'd1, d); chk("R6 pending cleared", 32'(d[15]), 0);
    chk("R8 write while busy ignored", 32'(d[11:10]), 1);
    chk("R8 cs1 held", 32'(cs_n), 32'hD);
  endtask

  task automatic t_rx_only;
    int cyc; bit pd; logic [15:0] d;
    xfer(0, 0, 16, 16'hFFFF, 16'h9E61, 1'b0, cyc, pd);
    chk("R4 busy cycles rx only", 32'(cyc), 32);
    chk("R7 sdo low with tx 0", pack(m_sec, 16), 0);
    bus_read(3'd0, d); chk("R7 rx only data", 32'(d), 32'h9E61);
  endtask

  task automatic t_edges;
    int cyc; bit pd; logic [15:0] d;
    bus_write(3'd3, 16'h000B);  // cs2: launch 1, sample 1, divider 2
    xfer(2, 4, 4, 16'h9000, 16'h0006, 1'b0, cyc, pd);
    chk("R9 cs2 divider busy cycles", 32'(cyc), 64);
    chk("R10 launch at first edge", pack(m_pre, 4), 32'h4);
    chk("R5 sdo word late launch", pack(m_sec, 4), 32'h9);
    bus_read(3'd0, d); chk("R11 sampled at second edge", 32'(d), 32'h0009);
    chk("R8 cs2 held", 32'(cs_n), 32'hB);
    bus_write(3'd1, 16'h0800);
    chk("R8 cs released", 32'(cs_n), 32'hF);
  endtask

  task automatic t_pol;
    bus_write(3'd3, 16'h080B);
    chk("R12 active-high idle low", 32'(cs_n), 32'h7);
    bus_write(3'd1, 16'h1C00);
    chk("R12 active-high asserted", 32'(cs_n), 32'hF);
    bus_write(3'd1, 16'h0000);
    chk("R12 released", 32'(cs_n), 32'h7);
  endtask

  task automatic t_inv;
    int cyc; bit pd;
    bus_write(3'd5, 16'h0001);
    chk("R13 idle high", 32'(sclk), 1);
    xfer(0, 4, 0, 16'h6000, 16'h0, 1'b0, cyc, pd);
    chk("R13 edges counted", 32'(m_edges), 8);
    chk("R13 sdo word inverted clock", pack(m_sec, 4), 32'h6);
    chk("R4 busy cycles inverted", 32'(cyc), 8);
    chk("R13 back to idle high", 32'(sclk), 1);
    chk("R12 mixed polarity pins", 32'(cs_n), 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_regs(); t_enable(); t_tx(); t_rx(); t_rx_only();
    t_edges(); t_pol(); t_inv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule